// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide internal form and turns it into a 32-bit IEEE-754 single-precision word. The internal form has a sign, a two-bit kind code, a signed unbiased exponent, and a 64-bit mantissa whose leading one sits at the top bit. A separate sticky bit stands for any bits lost further down. The packer rounds in one of four directions. It builds subnormal results, picks infinity or the largest finite value on overflow, and passes zeros, infinities and NaNs straight through.

Each result comes with a 5-bit result-class code and four exception flags. An optional status-update request folds these into a status register in the same cycle. Producing the internal value, other formats and trap delivery all happen outside this block. A result appears one clock after the input is accepted.

Top module: `sp_result_packer`

## Requirements
- R1: While reset is held, out_valid, out_word, out_class, out_flags and out_status are all zero.
- R2: Inputs are taken on a clock edge with in_valid high. The result appears on the next edge with out_valid high for exactly that one cycle, and out_valid is low in every other cycle.
- R3: in_kind 3 (NaN) gives the input sign, exponent 255, and fraction in_mant[62:40] with fraction bit 22 forced to 1. out_class is C|FU and no flag is raised.
- R4: in_kind 2 (infinity) gives the sign, exponent 255 and a zero fraction. out_class is FU plus FL when negative or FG when positive, and no flag is raised.
- R5: in_kind 0 (zero) gives a signed zero. out_class is FE, plus C when the sign is negative, and no flag is raised.
- R6: For in_kind 1, the significand is in_mant[63:40], guard is bit 39, round is bit 38, and sticky is the OR of bits 37:0 with in_sticky. in_rmode selects the rounding: 0 is nearest (ties go to even), 1 is toward zero, 2 is toward +inf, 3 is toward -inf. Inexact is guard|round|sticky. The rounded flag is set exactly when the significand was incremented.
- R7: A rounding carry out of the significand raises the biased exponent by one and clears the fraction.
- R8: If the biased exponent after rounding is 255 or more, overflow and inexact are raised. The result is infinity (class FU plus the sign flag) when the mode is nearest, or +inf mode with a positive value, or -inf mode with a negative value. Otherwise the result is the signed largest finite value: exponent 254, all fraction bits set, class equal to the sign flag.
- R9: When exponent+127 is at most 0, the value is shifted right by 1-(exponent+127) bits before rounding, and every bit shifted out feeds sticky. An exact subnormal result has class C plus the sign flag and raises no underflow.
- R10: A subnormal that rounds up to the smallest normal gives exponent 1 with a zero fraction. Its class is only the sign flag, and underflow is not raised.
- R11: An inexact subnormal raises underflow. If its fraction rounds to zero, the output is a signed zero with class FE only. Otherwise the output is the subnormal with class C plus the sign flag.
- R12: out_class bits 4..0 are C, FL, FG, FE, FU. A normal, non-overflowing result has FL when negative and FG when positive. out_flags bits 3..0 are overflow, underflow, rounded, inexact.
- R13: out_status bits 4..0 hold the class, bit 5 inexact, bit 6 rounded, and bits 7, 8, 9 are sticky inexact, underflow and overflow. With in_valid and in_stat_upd both high, bits 6..0 are replaced by the new result and bits 9..7 OR in the new flags. Otherwise out_status holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value is presented this cycle |
| in_sign | input | 1 | Sign of the value |
| in_kind | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_exp | input | EXP_W (12) | Signed unbiased exponent |
| in_mant | input | MANT_W (64) | Mantissa, leading one at the top bit |
| in_sticky | input | 1 | OR of bits below the mantissa |
| in_rmode | input | 2 | Rounding direction |
| in_stat_upd | input | 1 | Fold this result into the status register |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Packed single-precision word |
| out_class | output | 5 | Result-class code |
| out_flags | output | 4 | Exception flags |
| out_status | output | 10 | Status register |

## Verification
The assertions check on every cycle that out_valid is a one-cycle echo of in_valid, and that overflow, underflow and rounded never appear without inexact. They also check that FL and FG are never set together, and that a zero word always carries FE. On the status side they check that the sticky bits never fall and that the register holds when no update is requested. Only the bench's vectors can show that the packed words are numerically right. That covers ties going to even, the carry into the exponent, infinity versus largest finite under each mode and sign, the promotion of a subnormal to the smallest normal, and the point where a subnormal rounds to zero.

// File: rtl/spk_pkg.sv
package spk_pkg;

   typedef enum logic [1:0] {
      KIND_ZERO = 2'd0,
      KIND_NUM  = 2'd1,
      KIND_INF  = 2'd2,
      KIND_NAN  = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_POS  = 2'd2,
      RM_NEG  = 2'd3
   } rmode_e;

   // result-class bit positions
   localparam int CLS_W  = 5;
   localparam int CLS_C  = 4;
   localparam int CLS_FL = 3;
   localparam int CLS_FG = 2;
   localparam int CLS_FE = 1;
   localparam int CLS_FU = 0;

   // flag bit positions
   localparam int FLG_W   = 4;
   localparam int FLG_INX = 0;
   localparam int FLG_RND = 1;
   localparam int FLG_UNF = 2;
   localparam int FLG_OVF = 3;

   // status register layout
   localparam int ST_W  = 10;
   localparam int ST_FI = 5;
   localparam int ST_FR = 6;
   localparam int ST_XX = 7;
   localparam int ST_UX = 8;
   localparam int ST_OX = 9;

   function automatic logic [CLS_W-1:0] sign_cls(input logic neg);
      logic [CLS_W-1:0] c;
      c = '0;
      if (neg) c[CLS_FL] = 1'b1;
      else     c[CLS_FG] = 1'b1;
      return c;
   endfunction

endpackage

// File: rtl/spk_denorm_shift.sv
module spk_denorm_shift #(
   parameter int MANT_W = 64,
   parameter int SH_W   = 7
) (
   input  logic [MANT_W-1:0] mant_i,
   input  logic [SH_W-1:0]   sh_i,
   output logic [MANT_W-1:0] mant_o,
   output logic              lost_o
);

   localparam int MIN_SH_W = $clog2(MANT_W + 1);

   generate
      if (SH_W < MIN_SH_W) begin : g_bad_sh
         $error("spk_denorm_shift: SH_W too narrow for MANT_W");
      end
   endgenerate

   logic [MANT_W-1:0] low_mask;

   // bit i is shifted out when the shift amount exceeds i
   generate
      for (genvar i = 0; i < MANT_W; i++) begin : g_mask
         assign low_mask[i] = (sh_i > SH_W'(i));
      end
   endgenerate

   assign mant_o = mant_i >> sh_i;
   assign lost_o = |(mant_i & low_mask);

endmodule

// File: rtl/spk_rounder.sv
module spk_rounder
   import spk_pkg::*;
#(
   parameter int MANT_W = 64,
   parameter int SIG_W  = 24
) (
   input  logic [MANT_W-1:0] mant_i,
   input  logic              stk_i,
   input  logic              sign_i,
   input  rmode_e            mode_i,
   output logic [SIG_W:0]    sum_o,
   output logic              inexact_o,
   output logic              up_o
);

   localparam int LOW_W = MANT_W - SIG_W;

   generate
      if (LOW_W < 3) begin : g_bad_low
         $error("spk_rounder: need guard, round and sticky below the significand");
      end
   endgenerate

   logic [SIG_W-1:0] sig;
   logic             g_bit, r_bit, s_bit;

   assign sig   = mant_i[MANT_W-1 -: SIG_W];
   assign g_bit = mant_i[LOW_W-1];
   assign r_bit = mant_i[LOW_W-2];
   assign s_bit = (|mant_i[LOW_W-3:0]) | stk_i;

   assign inexact_o = g_bit | r_bit | s_bit;

   always_comb begin
      case (mode_i)
         RM_NEAR: up_o = g_bit & (r_bit | s_bit | sig[0]);
         RM_ZERO: up_o = 1'b0;
         RM_POS:  up_o = inexact_o & ~sign_i;
         RM_NEG:  up_o = inexact_o & sign_i;
         default: up_o = 1'b0;
      endcase
   end

   assign sum_o = {1'b0, sig} + {{SIG_W{1'b0}}, up_o};

endmodule

// File: rtl/spk_status.sv
module spk_status
   import spk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CLS_W-1:0] cls_i,
   input  logic [FLG_W-1:0] flg_i,
   output logic [ST_W-1:0]  status_o
);

   logic [ST_W-1:0] st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (load_i) begin
         st_q[CLS_W-1:0] <= cls_i;
         st_q[ST_FI]     <= flg_i[FLG_INX];
         st_q[ST_FR]     <= flg_i[FLG_RND];
         st_q[ST_XX]     <= st_q[ST_XX] | flg_i[FLG_INX];
         st_q[ST_UX]     <= st_q[ST_UX] | flg_i[FLG_UNF];
         st_q[ST_OX]     <= st_q[ST_OX] | flg_i[FLG_OVF];
      end
   end

   assign status_o = st_q;

   p_sticky_ox_r13: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[ST_OX] |=> st_q[ST_OX]);
   p_sticky_ux_r13: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[ST_UX] |=> st_q[ST_UX]);
   p_sticky_xx_r13: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[ST_XX] |=> st_q[ST_XX]);
   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(st_q));

endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
   import spk_pkg::*;
#(
   parameter int EXP_W     = 12,
   parameter int MANT_W    = 64,
   parameter int EXP_OUT_W = 8,
   parameter int FRAC_W    = 23
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic                           in_sign,
   input  logic [1:0]                     in_kind,
   input  logic [EXP_W-1:0]               in_exp,
   input  logic [MANT_W-1:0]              in_mant,
   input  logic                           in_sticky,
   input  logic [1:0]                     in_rmode,
   input  logic                           in_stat_upd,
   output logic                           out_valid,
   output logic [EXP_OUT_W+FRAC_W:0]      out_word,
   output logic [4:0]                     out_class,
   output logic [3:0]                     out_flags,
   output logic [9:0]                     out_status
);

   localparam int SIG_W  = FRAC_W + 1;
   localparam int WORD_W = 1 + EXP_OUT_W + FRAC_W;
   localparam int BIAS   = (1 << (EXP_OUT_W - 1)) - 1;
   localparam int EMAX   = (1 << EXP_OUT_W) - 1;
   localparam int BW     = EXP_W + 2;
   localparam int SH_W   = $clog2(MANT_W + 1);

   generate
      if (MANT_W < SIG_W + 3) begin : g_bad_mant
         $error("sp_result_packer: mantissa too narrow for guard/round/sticky");
      end
      if (BW <= SH_W) begin : g_bad_exp
         $error("sp_result_packer: exponent too narrow for shift range");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("sp_result_packer: fraction too narrow");
      end
   endgenerate

   kind_e  kind;
   rmode_e mode;
   assign kind = kind_e'(in_kind);
   assign mode = rmode_e'(in_rmode);

   // exponent arithmetic
   logic signed [BW-1:0] biased, sh_full, exp_after;
   logic                 subn;
   logic [SH_W-1:0]      sh_amt;

   always_comb begin
      biased  = {{2{in_exp[EXP_W-1]}}, in_exp} + BW'(BIAS);
      subn    = (biased <= 0);
      sh_full = $signed(BW'(1)) - biased;
      if (!subn)
         sh_amt = '0;
      else if (sh_full > $signed(BW'(MANT_W)))
         sh_amt = SH_W'(MANT_W);
      else
         sh_amt = sh_full[SH_W-1:0];
   end

   // alignment and rounding
   logic [MANT_W-1:0] mant_al;
   logic              lost;
   logic [SIG_W:0]    rsum;
   logic              inexact, rup;

   spk_denorm_shift #(.MANT_W(MANT_W), .SH_W(SH_W)) u_shift (
      .mant_i (in_mant),
      .sh_i   (sh_amt),
      .mant_o (mant_al),
      .lost_o (lost)
   );

   spk_rounder #(.MANT_W(MANT_W), .SIG_W(SIG_W)) u_round (
      .mant_i    (mant_al),
      .stk_i     (in_sticky | lost),
      .sign_i    (in_sign),
      .mode_i    (mode),
      .sum_o     (rsum),
      .inexact_o (inexact),
      .up_o      (rup)
   );

   logic carry, promote, ovf, to_inf;

   always_comb begin
      carry     = rsum[SIG_W];
      promote   = rsum[FRAC_W];
      exp_after = biased + $signed({{(BW-1){1'b0}}, carry});
      ovf       = (exp_after >= $signed(BW'(EMAX)));
      to_inf    = (mode == RM_NEAR) | ((mode == RM_POS) & ~in_sign) |
                  ((mode == RM_NEG) & in_sign);
   end

   // result encoding
   logic [WORD_W-1:0] word_d;
   logic [CLS_W-1:0]  cls_d;
   logic [FLG_W-1:0]  flg_d;

   always_comb begin
      word_d = '0;
      cls_d  = '0;
      flg_d  = '0;
      case (kind)
         KIND_NAN: begin
            word_d = {in_sign, {EXP_OUT_W{1'b1}}, 1'b1,
                      in_mant[MANT_W-3 -: FRAC_W-1]};
            cls_d[CLS_C]  = 1'b1;
            cls_d[CLS_FU] = 1'b1;
         end
         KIND_INF: begin
            word_d = {in_sign, {EXP_OUT_W{1'b1}}, {FRAC_W{1'b0}}};
            cls_d  = sign_cls(in_sign);
            cls_d[CLS_FU] = 1'b1;
         end
         KIND_ZERO: begin
            word_d = {in_sign, {(WORD_W-1){1'b0}}};
            cls_d[CLS_FE] = 1'b1;
            cls_d[CLS_C]  = in_sign;
         end
         KIND_NUM: begin
            flg_d[FLG_INX] = inexact;
            flg_d[FLG_RND] = rup;
            if (subn) begin
               if (promote) begin
                  word_d = {in_sign, EXP_OUT_W'(1), {FRAC_W{1'b0}}};
                  cls_d  = sign_cls(in_sign);
               end else if (inexact && (rsum == '0)) begin
                  word_d = {in_sign, {(WORD_W-1){1'b0}}};
                  cls_d[CLS_FE]  = 1'b1;
                  flg_d[FLG_UNF] = 1'b1;
               end else begin
                  word_d = {in_sign, {EXP_OUT_W{1'b0}}, rsum[FRAC_W-1:0]};
                  cls_d  = sign_cls(in_sign);
                  cls_d[CLS_C]   = 1'b1;
                  flg_d[FLG_UNF] = inexact;
               end
            end else if (ovf) begin
               flg_d[FLG_OVF] = 1'b1;
               flg_d[FLG_INX] = 1'b1;
               cls_d = sign_cls(in_sign);
               if (to_inf) begin
                  word_d = {in_sign, {EXP_OUT_W{1'b1}}, {FRAC_W{1'b0}}};
                  cls_d[CLS_FU] = 1'b1;
               end else begin
                  word_d = {in_sign, EXP_OUT_W'(EMAX - 1), {FRAC_W{1'b1}}};
               end
            end else begin
               word_d = {in_sign, exp_after[EXP_OUT_W-1:0], rsum[FRAC_W-1:0]};
               cls_d  = sign_cls(in_sign);
            end
         end
         default: ;
      endcase
   end

   // output register
   logic              vld_q;
   logic [WORD_W-1:0] word_q;
   logic [CLS_W-1:0]  cls_q;
   logic [FLG_W-1:0]  flg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         word_q <= '0;
         cls_q  <= '0;
         flg_q  <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            word_q <= word_d;
            cls_q  <= cls_d;
            flg_q  <= flg_d;
         end
      end
   end

   spk_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (in_valid & in_stat_upd),
      .cls_i    (cls_d),
      .flg_i    (flg_d),
      .status_o (out_status)
   );

   assign out_valid = vld_q;
   assign out_word  = word_q;
   assign out_class = cls_q;
   assign out_flags = flg_q;

   p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_ovf_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_flags[FLG_OVF] |-> out_flags[FLG_INX]);
   p_unf_inexact_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_flags[FLG_UNF] |-> out_flags[FLG_INX]);
   p_rnd_inexact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_flags[FLG_RND] |-> out_flags[FLG_INX]);
   p_sign_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_class[CLS_FL] && out_class[CLS_FG]));
   p_zero_fe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_word[WORD_W-2:0] == '0)) |-> out_class[CLS_FE]);

endmodule

// File: tb/sp_result_packer_tb.sv
`timescale 1ns/1ps
module sp_result_packer_tb;

   typedef struct packed {
      logic        sg;
      logic [1:0]  kd;
      logic [11:0] ex;
      logic [63:0] mn;
      logic        sk;
      logic [1:0]  md;
      logic [31:0] wd;
      logic [4:0]  cl;
      logic [3:0]  fl;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b0, 2'd1, 12'h000, 64'h8000000000000000, 1'b0, 2'd0, 32'h3F800000, 5'h04, 4'h0},
      '{1'b1, 2'd1, 12'h000, 64'h8000000000000000, 1'b0, 2'd0, 32'hBF800000, 5'h08, 4'h0},
      '{1'b0, 2'd1, 12'h000, 64'h8000008000000000, 1'b0, 2'd0, 32'h3F800000, 5'h04, 4'h1},
      '{1'b0, 2'd1, 12'h000, 64'h8000008000000000, 1'b0, 2'd2, 32'h3F800001, 5'h04, 4'h3},
      '{1'b0, 2'd1, 12'h000, 64'h8000008000000000, 1'b0, 2'd3, 32'h3F800000, 5'h04, 4'h1},
      '{1'b0, 2'd1, 12'h000, 64'h8000008000000000, 1'b0, 2'd1, 32'h3F800000, 5'h04, 4'h1},
      '{1'b0, 2'd1, 12'h000, 64'h8000018000000000, 1'b0, 2'd0, 32'h3F800002, 5'h04, 4'h3},
      '{1'b0, 2'd1, 12'h000, 64'h8000008000000000, 1'b1, 2'd0, 32'h3F800001, 5'h04, 4'h3},
      '{1'b1, 2'd1, 12'h000, 64'h8000004000000000, 1'b0, 2'd3, 32'hBF800001, 5'h08, 4'h3},
      '{1'b1, 2'd1, 12'h000, 64'h8000004000000000, 1'b0, 2'd0, 32'hBF800000, 5'h08, 4'h1},
      '{1'b0, 2'd1, 12'h000, 64'hFFFFFF8000000000, 1'b0, 2'd0, 32'h40000000, 5'h04, 4'h3},
      '{1'b0, 2'd1, 12'h07F, 64'hFFFFFF8000000000, 1'b0, 2'd0, 32'h7F800000, 5'h05, 4'hB},
      '{1'b0, 2'd1, 12'h07F, 64'hFFFFFF8000000000, 1'b0, 2'd1, 32'h7F7FFFFF, 5'h04, 4'h1},
      '{1'b0, 2'd1, 12'h080, 64'h8000000000000000, 1'b0, 2'd1, 32'h7F7FFFFF, 5'h04, 4'h9},
      '{1'b1, 2'd1, 12'h080, 64'h8000000000000000, 1'b0, 2'd2, 32'hFF7FFFFF, 5'h08, 4'h9},
      '{1'b1, 2'd1, 12'h080, 64'h8000000000000000, 1'b0, 2'd3, 32'hFF800000, 5'h09, 4'h9},
      '{1'b0, 2'd1, 12'h0C8, 64'h8000000000000000, 1'b0, 2'd0, 32'h7F800000, 5'h05, 4'h9},
      '{1'b0, 2'd1, 12'hF81, 64'h8000000000000000, 1'b0, 2'd0, 32'h00400000, 5'h14, 4'h0},
      '{1'b0, 2'd1, 12'hF6B, 64'h8000000000000000, 1'b0, 2'd0, 32'h00000001, 5'h14, 4'h0},
      '{1'b0, 2'd1, 12'hF6A, 64'h8000000000000000, 1'b0, 2'd0, 32'h00000000, 5'h02, 4'h5},
      '{1'b0, 2'd1, 12'hF6A, 64'h8000000000000000, 1'b0, 2'd2, 32'h00000001, 5'h14, 4'h7},
      '{1'b1, 2'd1, 12'hF6A, 64'hC000000000000000, 1'b0, 2'd0, 32'h80000001, 5'h18, 4'h7},
      '{1'b0, 2'd1, 12'hF81, 64'hFFFFFFFFFFFFFFFF, 1'b0, 2'd0, 32'h00800000, 5'h04, 4'h3},
      '{1'b0, 2'd1, 12'hF81, 64'hFFFFFFFFFFFFFFFF, 1'b0, 2'd1, 32'h007FFFFF, 5'h14, 4'h5},
      '{1'b0, 2'd1, 12'h830, 64'h8000000000000000, 1'b0, 2'd2, 32'h00000001, 5'h14, 4'h7},
      '{1'b0, 2'd3, 12'h000, 64'hC123456789ABCDEF, 1'b0, 2'd0, 32'h7FC12345, 5'h11, 4'h0},
      '{1'b1, 2'd3, 12'h005, 64'h8012340000000000, 1'b1, 2'd2, 32'hFFC01234, 5'h11, 4'h0},
      '{1'b0, 2'd2, 12'h033, 64'h1234000000000000, 1'b1, 2'd0, 32'h7F800000, 5'h05, 4'h0},
      '{1'b1, 2'd2, 12'h000, 64'h0000000000000000, 1'b0, 2'd3, 32'hFF800000, 5'h09, 4'h0},
      '{1'b0, 2'd0, 12'h000, 64'h0000000000000000, 1'b0, 2'd0, 32'h00000000, 5'h02, 4'h0},
      '{1'b1, 2'd0, 12'h044, 64'hFFFF000000000000, 1'b1, 2'd2, 32'h80000000, 5'h12, 4'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sign = 1'b0;
   logic [1:0]  in_kind = '0;
   logic [11:0] in_exp = '0;
   logic [63:0] in_mant = '0;
   logic        in_sticky = 1'b0;
   logic [1:0]  in_rmode = '0;
   logic        in_stat_upd = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;
   logic [4:0]  out_class;
   logic [3:0]  out_flags;
   logic [9:0]  out_status;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   sp_result_packer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_sign     (in_sign),
      .in_kind     (in_kind),
      .in_exp      (in_exp),
      .in_mant     (in_mant),
      .in_sticky   (in_sticky),
      .in_rmode    (in_rmode),
      .in_stat_upd (in_stat_upd),
      .out_valid   (out_valid),
      .out_word    (out_word),
      .out_class   (out_class),
      .out_flags   (out_flags),
      .out_status  (out_status)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // drive one value at a falling edge; outputs are settled at the next falling edge
   task automatic send(input vec_t v, input logic upd);
      in_sign     = v.sg;
      in_kind     = v.kd;
      in_exp      = v.ex;
      in_mant     = v.mn;
      in_sticky   = v.sk;
      in_rmode    = v.md;
      in_stat_upd = upd;
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid    = 1'b0;
      in_stat_upd = 1'b0;
   endtask

   function automatic string req_of(input int i);
      if (i < 2)        return "R12";
      else if (i < 10)  return "R6";
      else if (i < 11)  return "R7";
      else if (i < 17)  return "R8";
      else if (i < 19)  return "R9";
      else if (i < 22)  return "R11";
      else if (i < 23)  return "R10";
      else if (i < 25)  return "R11";
      else if (i < 27)  return "R3";
      else if (i < 29)  return "R4";
      else              return "R5";
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "valid", 32'(out_valid), 32'h0);
      chk("R1", "word", out_word, 32'h0);
      chk("R1", "class", 32'(out_class), 32'h0);
      chk("R1", "flags", 32'(out_flags), 32'h0);
      chk("R1", "status", 32'(out_status), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         send(VECS[i], 1'b0);
         chk("R2", "valid", 32'(out_valid), 32'h1);
         chk(req_of(i), $sformatf("word v%0d", i), out_word, VECS[i].wd);
         chk(req_of(i), $sformatf("class v%0d", i), 32'(out_class), 32'(VECS[i].cl));
         chk(req_of(i), $sformatf("flags v%0d", i), 32'(out_flags), 32'(VECS[i].fl));
      end

      @(negedge clk);
      chk("R2", "valid after idle", 32'(out_valid), 32'h0);
      chk("R13", "status untouched without update", 32'(out_status), 32'h0);

      // R13: status folding
      send(VECS[16], 1'b1);   // overflow to +inf, exact mantissa
      chk("R13", "status after overflow", 32'(out_status), 32'h2A5);
      send(VECS[0], 1'b1);    // exact 1.0
      chk("R13", "status after exact", 32'(out_status), 32'h284);
      send(VECS[19], 1'b0);   // underflow without update request
      chk("R13", "status held", 32'(out_status), 32'h284);
      chk("R11", "flags of unrequested", 32'(out_flags), 32'h5);
      send(VECS[20], 1'b1);   // rounded-up subnormal with underflow
      chk("R13", "status after underflow", 32'(out_status), 32'h3F4);

      // R1: reset clears everything again
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "status after reset", 32'(out_status), 32'h0);
      chk("R1", "word after reset", out_word, 32'h0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R2 watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule